// File: doc/BRIEF.md
# Rotating-Store Transfer Timing Sequencer

This block times one register-to-register transfer for a machine whose storage recirculates through a fixed ring of 32 minor cycles, which make up one major cycle. A free-running minor-cycle counter marks which slot is passing. A decoded instruction is loaded with a one-cycle handshake. It carries its own slot position `m`, a wait number `W`, a timing number `T`, a 2-bit characteristic, source and destination codes, and a next-instruction source. The sequencer then opens a transfer gate in the right minor cycles. It also pulses a fetch strobe, with the slot address, in the cycle when the next instruction passes.

All slot arithmetic is relative to the instruction's own slot and wraps modulo 32. The gate opens at slot `m+W+2`. The fetch happens at slot `m+T+2`. The characteristic selects one of three gate lengths. A prolonged span runs up to and including the fetch slot, a single-word transfer lasts one cycle and a double-word transfer lasts two. The fourth characteristic code is rejected as illegal. Storage lines, arithmetic units and the serial data path are outside this block.

Top module: `rxs_seq_top`

## Requirements
- R1: After reset, `minor_cycle` is 0, `ins_ready` is 1, and `xfer_en`, `fetch_strobe` and `illegal` are 0. While out of reset, `minor_cycle` rises by one every clock and wraps from 31 to 0.
- R2: An instruction is taken in a cycle where `ins_valid` and `ins_ready` are both high. `ins_ready` is low from the next cycle until the instruction has finished both its fetch and its gate. `ins_valid` has no effect while `ins_ready` is low. `xfer_en` and `fetch_strobe` are never high while `ins_ready` is high.
- R3: The gate of an instruction opens in the first cycle after the load cycle in which `minor_cycle` equals (m+W+2) mod 32.
- R4: Exactly one single-cycle `fetch_strobe` is issued per instruction. It comes in the first cycle at or after the gate start where `minor_cycle` equals (m+T+2) mod 32. That cycle lies ((T−W) mod 32) cycles after the gate start. `fetch_slot_o` then carries (m+T+2) mod 32 and `fetch_src` carries the next-source code.
- R5: With characteristic code 2'b00, `xfer_en` is high for ((T−W) mod 32)+1 consecutive cycles. Its last cycle is the fetch cycle, so a T below W wraps and does not go negative.
- R6: With characteristic code 2'b01, `xfer_en` is high for exactly one cycle, the gate start.
- R7: With characteristic code 2'b11, `xfer_en` is high for exactly two consecutive cycles from the gate start. This holds even when T equals W, where the fetch falls on the first of them.
- R8: With characteristic code 2'b10, `illegal` is high from the cycle after the load until the instruction completes. `xfer_en` stays low, and the fetch is still issued as in R4.
- R9: While `xfer_en` is high, `xfer_src` and `xfer_dst` carry the source and destination codes of the instruction being executed.
- R10: Slot sums wrap at 32. For example, m=31 with W=T=0 gates and fetches at slot 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one minor cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Decoded instruction offered |
| ins_ready | output | 1 | Sequencer idle and able to take an instruction |
| ins_slot | input | SLOT_W | Slot m that holds the instruction |
| ins_wait | input | SLOT_W | Wait number W |
| ins_timing | input | SLOT_W | Timing number T |
| ins_char | input | 2 | Characteristic: 00 span, 01 one word, 11 two words, 10 illegal |
| ins_src | input | SRC_W | Source code |
| ins_dst | input | DST_W | Destination code |
| ins_next_src | input | NIS_W | Store that supplies the next instruction |
| minor_cycle | output | SLOT_W | Free-running minor-cycle counter |
| xfer_en | output | 1 | Transfer gate |
| xfer_src | output | SRC_W | Source code of the current instruction |
| xfer_dst | output | DST_W | Destination code of the current instruction |
| fetch_strobe | output | 1 | One-cycle next-instruction fetch pulse |
| fetch_slot_o | output | SLOT_W | Slot of the next instruction |
| fetch_src | output | NIS_W | Next-instruction source code |
| illegal | output | 1 | Characteristic code 10 is being held |

## Verification
The hardest case is a prolonged span with T below W. Its gate crosses the counter's wrap from 31 to 0 and lasts 30 cycles, so the modulo length, the start slot and the fetch coincidence must all hold across the wrap. The stimulus loads m=20, W=5, T=2. While that instruction is pending, the bench holds `ins_valid` high with junk fields and confirms that nothing extra appears on the gate or the strobe. A double-word instruction with T equal to W is also driven, so the fetch lands on the first gate cycle while the second gate cycle still follows.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  typedef enum logic [1:0] {
    XC_SPAN = 2'd0,
    XC_ONE  = 2'd1,
    XC_BAD  = 2'd2,
    XC_PAIR = 2'd3
  } xfer_char_e;
endpackage

// File: rtl/rxs_slot_counter.sv
module rxs_slot_counter #(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  output logic [SLOT_W-1:0] cnt_q,
  output logic [SLOT_W-1:0] cnt_nxt
);
  localparam logic [SLOT_W-1:0] STEP = SLOT_W'(1);

  assign cnt_nxt = cnt_q + STEP;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/rxs_instr_hold.sv
module rxs_instr_hold
  import rxs_pkg::*;
#(
  parameter int SLOT_W = 5,
  parameter int SRC_W  = 5,
  parameter int DST_W  = 5,
  parameter int NIS_W  = 3,
  parameter int LEAD   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_acc,
  input  logic [SLOT_W-1:0] ins_slot,
  input  logic [SLOT_W-1:0] ins_wait,
  input  logic [SLOT_W-1:0] ins_timing,
  input  logic [1:0]        ins_char,
  input  logic [SRC_W-1:0]  ins_src,
  input  logic [DST_W-1:0]  ins_dst,
  input  logic [NIS_W-1:0]  ins_nis,
  output xfer_char_e        cur_char,
  output logic [SRC_W-1:0]  cur_src,
  output logic [DST_W-1:0]  cur_dst,
  output logic [NIS_W-1:0]  cur_nis,
  output logic [SLOT_W-1:0] start_slot,
  output logic [SLOT_W-1:0] fetch_slot,
  output logic [SLOT_W-1:0] fetch_off,
  output logic [SLOT_W-1:0] xfer_last,
  output logic [SLOT_W-1:0] done_off
);
  localparam logic [SLOT_W-1:0] LEAD_C = SLOT_W'(LEAD);

  logic [SLOT_W-1:0] h_slot, h_wait, h_timing;
  xfer_char_e        h_char;
  logic [SRC_W-1:0]  h_src;
  logic [DST_W-1:0]  h_dst;
  logic [NIS_W-1:0]  h_nis;
  logic [SLOT_W-1:0] c_slot, c_wait, c_timing;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_slot   <= '0;
      h_wait   <= '0;
      h_timing <= '0;
      h_char   <= XC_SPAN;
      h_src    <= '0;
      h_dst    <= '0;
      h_nis    <= '0;
    end else if (load_acc) begin
      h_slot   <= ins_slot;
      h_wait   <= ins_wait;
      h_timing <= ins_timing;
      h_char   <= xfer_char_e'(ins_char);
      h_src    <= ins_src;
      h_dst    <= ins_dst;
      h_nis    <= ins_nis;
    end
  end

  // The instruction that governs the upcoming cycle: the incoming one on a load.
  always_comb begin
    if (load_acc) begin
      c_slot   = ins_slot;
      c_wait   = ins_wait;
      c_timing = ins_timing;
      cur_char = xfer_char_e'(ins_char);
      cur_src  = ins_src;
      cur_dst  = ins_dst;
      cur_nis  = ins_nis;
    end else begin
      c_slot   = h_slot;
      c_wait   = h_wait;
      c_timing = h_timing;
      cur_char = h_char;
      cur_src  = h_src;
      cur_dst  = h_dst;
      cur_nis  = h_nis;
    end
  end

  // Slot sums wrap naturally in SLOT_W bits (modulo 32 by default).
  assign start_slot = c_slot + c_wait + LEAD_C;
  assign fetch_slot = c_slot + c_timing + LEAD_C;
  assign fetch_off  = c_timing - c_wait;

  always_comb begin
    case (cur_char)
      XC_SPAN: xfer_last = fetch_off;
      XC_PAIR: xfer_last = SLOT_W'(1);
      default: xfer_last = '0;
    endcase
    if (cur_char == XC_PAIR && fetch_off == '0) done_off = SLOT_W'(1);
    else                                        done_off = fetch_off;
  end
endmodule

// File: rtl/rxs_window_fsm.sv
module rxs_window_fsm #(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_acc,
  input  logic [SLOT_W-1:0] cnt_nxt,
  input  logic [SLOT_W-1:0] start_slot,
  input  logic [SLOT_W-1:0] done_off,
  output logic              ready,
  output logic              run_n,
  output logic              hold_n,
  output logic [SLOT_W-1:0] k_n
);
  logic              wait_q, run_q, wait_n;
  logic [SLOT_W-1:0] k_q;

  always_comb begin
    wait_n = 1'b0;
    run_n  = 1'b0;
    k_n    = k_q;
    if (load_acc || wait_q) begin
      if (cnt_nxt == start_slot) begin
        run_n = 1'b1;
        k_n   = '0;
      end else begin
        wait_n = 1'b1;
      end
    end else if (run_q && k_q != done_off) begin
      run_n = 1'b1;
      k_n   = k_q + SLOT_W'(1);
    end
  end

  assign hold_n = wait_n || run_n;
  assign ready  = !wait_q && !run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q <= 1'b0;
      run_q  <= 1'b0;
      k_q    <= '0;
    end else begin
      wait_q <= wait_n;
      run_q  <= run_n;
      k_q    <= k_n;
    end
  end

  p_take_drop_r2: assert property (@(posedge clk) disable iff (rst)
    load_acc |=> !ready);
  p_no_double_state_r2: assert property (@(posedge clk) disable iff (rst)
    !(wait_q && run_q));
endmodule

// File: rtl/rxs_seq_top.sv
module rxs_seq_top
  import rxs_pkg::*;
#(
  parameter int SLOT_W = 5,
  parameter int SRC_W  = 5,
  parameter int DST_W  = 5,
  parameter int NIS_W  = 3,
  parameter int LEAD   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [SLOT_W-1:0] ins_slot,
  input  logic [SLOT_W-1:0] ins_wait,
  input  logic [SLOT_W-1:0] ins_timing,
  input  logic [1:0]        ins_char,
  input  logic [SRC_W-1:0]  ins_src,
  input  logic [DST_W-1:0]  ins_dst,
  input  logic [NIS_W-1:0]  ins_next_src,
  output logic [SLOT_W-1:0] minor_cycle,
  output logic              xfer_en,
  output logic [SRC_W-1:0]  xfer_src,
  output logic [DST_W-1:0]  xfer_dst,
  output logic              fetch_strobe,
  output logic [SLOT_W-1:0] fetch_slot_o,
  output logic [NIS_W-1:0]  fetch_src,
  output logic              illegal
);
  logic              load_acc, run_n, hold_n;
  logic [SLOT_W-1:0] cnt_nxt, k_n;
  logic [SLOT_W-1:0] start_slot, fetch_slot, fetch_off, xfer_last, done_off;
  xfer_char_e        cur_char;
  logic [SRC_W-1:0]  cur_src;
  logic [DST_W-1:0]  cur_dst;
  logic [NIS_W-1:0]  cur_nis;

  assign load_acc = ins_valid && ins_ready;

  rxs_slot_counter #(.SLOT_W(SLOT_W)) u_cnt (
    .clk(clk), .rst(rst), .cnt_q(minor_cycle), .cnt_nxt(cnt_nxt)
  );

  rxs_instr_hold #(
    .SLOT_W(SLOT_W), .SRC_W(SRC_W), .DST_W(DST_W), .NIS_W(NIS_W), .LEAD(LEAD)
  ) u_hold (
    .clk(clk), .rst(rst), .load_acc(load_acc),
    .ins_slot(ins_slot), .ins_wait(ins_wait), .ins_timing(ins_timing),
    .ins_char(ins_char), .ins_src(ins_src), .ins_dst(ins_dst), .ins_nis(ins_next_src),
    .cur_char(cur_char), .cur_src(cur_src), .cur_dst(cur_dst), .cur_nis(cur_nis),
    .start_slot(start_slot), .fetch_slot(fetch_slot), .fetch_off(fetch_off),
    .xfer_last(xfer_last), .done_off(done_off)
  );

  rxs_window_fsm #(.SLOT_W(SLOT_W)) u_fsm (
    .clk(clk), .rst(rst), .load_acc(load_acc), .cnt_nxt(cnt_nxt),
    .start_slot(start_slot), .done_off(done_off),
    .ready(ins_ready), .run_n(run_n), .hold_n(hold_n), .k_n(k_n)
  );

  // Output stage: every output is registered and lines up with minor_cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_en      <= 1'b0;
      xfer_src     <= '0;
      xfer_dst     <= '0;
      fetch_strobe <= 1'b0;
      fetch_slot_o <= '0;
      fetch_src    <= '0;
      illegal      <= 1'b0;
    end else begin
      xfer_en      <= run_n && (k_n <= xfer_last) && (cur_char != XC_BAD);
      xfer_src     <= cur_src;
      xfer_dst     <= cur_dst;
      fetch_strobe <= run_n && (k_n == fetch_off);
      fetch_slot_o <= fetch_slot;
      fetch_src    <= cur_nis;
      illegal      <= hold_n && (cur_char == XC_BAD);
    end
  end

  logic chk_armed;
  always_ff @(posedge clk) begin
    if (rst) chk_armed <= 1'b0;
    else     chk_armed <= 1'b1;
  end

  p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
    chk_armed |-> minor_cycle == ($past(minor_cycle) + SLOT_W'(1)));
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    ins_ready |-> (!xfer_en && !fetch_strobe));
  p_start_slot_r3: assert property (@(posedge clk) disable iff (rst || !chk_armed)
    $rose(xfer_en) |-> minor_cycle == start_slot);
  p_fetch_slot_r4: assert property (@(posedge clk) disable iff (rst)
    fetch_strobe |-> minor_cycle == fetch_slot_o);
  p_single_fetch_r4: assert property (@(posedge clk) disable iff (rst)
    fetch_strobe |=> !fetch_strobe);
  p_span_end_r5: assert property (@(posedge clk) disable iff (rst || !chk_armed)
    ($fell(xfer_en) && $past(cur_char) == XC_SPAN) |-> $past(fetch_strobe));
  p_one_word_r6: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && cur_char == XC_ONE) |=> !xfer_en);
  p_two_word_r7: assert property (@(posedge clk) disable iff (rst || !chk_armed)
    ($rose(xfer_en) && cur_char == XC_PAIR) |=> xfer_en);
  p_bad_gate_r8: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !xfer_en);
endmodule

// File: tb/rxs_seq_top_tb_top.sv
`timescale 1ns/1ps
module rxs_seq_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ins_valid = 1'b0;
  logic       ins_ready;
  logic [4:0] ins_slot = '0, ins_wait = '0, ins_timing = '0;
  logic [1:0] ins_char = '0;
  logic [4:0] ins_src = '0, ins_dst = '0;
  logic [2:0] ins_next_src = '0;
  logic [4:0] minor_cycle;
  logic       xfer_en;
  logic [4:0] xfer_src, xfer_dst;
  logic       fetch_strobe;
  logic [4:0] fetch_slot_o;
  logic [2:0] fetch_src;
  logic       illegal;

  always #2 clk = ~clk;

  rxs_seq_top dut_i (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_slot(ins_slot), .ins_wait(ins_wait), .ins_timing(ins_timing),
    .ins_char(ins_char), .ins_src(ins_src), .ins_dst(ins_dst),
    .ins_next_src(ins_next_src), .minor_cycle(minor_cycle), .xfer_en(xfer_en),
    .xfer_src(xfer_src), .xfer_dst(xfer_dst), .fetch_strobe(fetch_strobe),
    .fetch_slot_o(fetch_slot_o), .fetch_src(fetch_src), .illegal(illegal)
  );

  typedef struct {
    int    cyc;
    int    a;
    int    b;
    int    bad;
    string rq;
  } ev_t;

  ev_t xq[$];
  ev_t fq[$];
  int  total = 0;
  int  bad = 0;
  int  cyc = 0;
  bit  done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // Driver: computes the expected gate and fetch events and queues them.
  task automatic load_ins(input int m, input int w, input int t, input int c,
                          input int src, input int dst, input int nis,
                          input string tag);
    int c0, cyc0, st, d, t0, dfo, len;
    while (!ins_ready) @(negedge clk);
    c0   = minor_cycle;
    cyc0 = cyc;
    st   = (m + w + 2) % 32;
    d    = ((st - c0 - 1 + 64) % 32) + 1;
    t0   = cyc0 + d;
    dfo  = (t - w + 32) % 32;
    case (c)
      0:       len = dfo + 1;
      1:       len = 1;
      3:       len = 2;
      default: len = 0;
    endcase
    for (int i = 0; i < len; i++) begin
      ev_t e;
      e.cyc = t0 + i; e.a = src; e.b = dst; e.bad = 0;
      e.rq  = (c == 0) ? {"R3 R5 R9 ", tag} : (c == 1) ? {"R3 R6 R9 ", tag}
                                             : {"R3 R7 R9 ", tag};
      xq.push_back(e);
    end
    begin
      ev_t f;
      f.cyc = t0 + dfo; f.a = (m + t + 2) % 32; f.b = nis; f.bad = (c == 2);
      f.rq  = {"R4 R8 ", tag};
      fq.push_back(f);
    end
    ins_slot = 5'(m); ins_wait = 5'(w); ins_timing = 5'(t); ins_char = 2'(c);
    ins_src = 5'(src); ins_dst = 5'(dst); ins_next_src = 3'(nis);
    ins_valid = 1'b1;
    @(negedge clk);
    ins_valid = 1'b0;
    chk(ins_ready == 1'b0, "R2", "ready after load", int'(ins_ready), 0);
  endtask

  // Monitor: pops expected events as the design produces them.
  bit have_prev = 0;
  int prev_mc = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (have_prev)
        chk(int'(minor_cycle) == (prev_mc + 1) % 32, "R1", "counter step",
            int'(minor_cycle), (prev_mc + 1) % 32);
      have_prev = 1;
      prev_mc   = minor_cycle;
      while (xq.size() > 0 && xq[0].cyc < cyc) begin
        chk(0, xq[0].rq, "missed gate cycle", cyc, xq[0].cyc);
        void'(xq.pop_front());
      end
      while (fq.size() > 0 && fq[0].cyc < cyc) begin
        chk(0, fq[0].rq, "missed fetch cycle", cyc, fq[0].cyc);
        void'(fq.pop_front());
      end
      if (xfer_en) begin
        if (xq.size() == 0 || xq[0].cyc != cyc) begin
          chk(0, "R2 R5 R6 R7 R8", "unexpected gate", 1, 0);
        end else begin
          ev_t e;
          e = xq.pop_front();
          chk(int'(xfer_src) == e.a, e.rq, "xfer_src", int'(xfer_src), e.a);
          chk(int'(xfer_dst) == e.b, e.rq, "xfer_dst", int'(xfer_dst), e.b);
        end
      end
      if (fetch_strobe) begin
        if (fq.size() == 0 || fq[0].cyc != cyc) begin
          chk(0, "R4", "unexpected fetch", 1, 0);
        end else begin
          ev_t f;
          f = fq.pop_front();
          chk(int'(fetch_slot_o) == f.a, f.rq, "fetch slot", int'(fetch_slot_o), f.a);
          chk(int'(minor_cycle) == f.a, f.rq, "fetch cycle slot", int'(minor_cycle), f.a);
          chk(int'(fetch_src) == f.b, f.rq, "fetch source", int'(fetch_src), f.b);
          chk(int'(illegal) == f.bad, f.rq, "illegal flag", int'(illegal), f.bad);
        end
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      chk(0, "R1", "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(minor_cycle == 5'd0, "R1", "reset counter", int'(minor_cycle), 0);
    chk(ins_ready == 1'b1, "R1", "reset ready", int'(ins_ready), 1);
    chk(!xfer_en && !fetch_strobe && !illegal, "R1", "reset outputs quiet",
        int'({xfer_en, fetch_strobe, illegal}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    load_ins(0, 0, 0, 1, 3, 4, 1, "");        // one word, fastest form
    load_ins(8, 0, 2, 0, 5, 6, 1, "");        // span of three cycles
    load_ins(31, 0, 0, 0, 7, 8, 2, "R10");    // wraps to slot 1
    chk(1 == (31 + 0 + 2) % 32, "R10", "wrap slot arithmetic", (31 + 2) % 32, 1);
    load_ins(1, 0, 3, 0, 9, 10, 1, "");       // span of four, fetch slot 6
    load_ins(4, 3, 3, 3, 11, 12, 3, "R7");    // pair with fetch on first cycle
    load_ins(10, 1, 6, 3, 13, 14, 4, "");     // pair, fetch well after
    load_ins(12, 2, 9, 2, 15, 16, 5, "R8");   // illegal code
    @(negedge clk);
    chk(illegal == 1'b1 || fq.size() == 0, "R8", "illegal held while pending",
        int'(illegal), 1);

    // Long wrapped span; junk offered while busy must be ignored (R2).
    load_ins(20, 5, 2, 0, 17, 18, 6, "R5 wrap");
    for (int i = 0; i < 3; i++) begin
      ins_slot = 5'd3; ins_wait = 5'd0; ins_timing = 5'd0; ins_char = 2'd1;
      ins_src = 5'd31; ins_dst = 5'd31; ins_next_src = 3'd7;
      ins_valid = 1'b1;
      @(negedge clk);
      chk(ins_ready == 1'b0, "R2", "busy refuses load", int'(ins_ready), 0);
    end
    ins_valid = 1'b0;

    load_ins(2, 0, 31, 1, 19, 20, 2, "");     // one word, distant fetch
    load_ins(30, 31, 31, 0, 21, 22, 3, "");   // W=T=31: single-cycle span
    load_ins(5, 0, 0, 3, 23, 24, 0, "");      // back-to-back pair

    for (int i = 0; i < 300 && !(ins_ready && xq.size() == 0 && fq.size() == 0); i++)
      @(negedge clk);
    repeat (40) @(negedge clk);
    chk(xq.size() == 0, "R5", "gate events left", xq.size(), 0);
    chk(fq.size() == 0, "R4", "fetch events left", fq.size(), 0);
    chk(ins_ready == 1'b1, "R2", "ready when drained", int'(ins_ready), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule